// File: doc/BRIEF.md
# Signed Saturating Vector Narrowing Unit

This unit takes a 128-bit source value made of packed signed integer lanes and produces lanes that are half as wide. Each value is clamped to the signed range of the narrower lane. The caller supplies a 32-bit instruction word. The unit decodes from it the narrow lane size, which form to run (a vector form or a single-lane scalar form), which half of the destination receives the result, and the source and destination register indices.

For the vector form the narrowed 64-bit result goes to the low half of the destination, with the high half cleared, or to the high half, with the low half taken from the old destination value the caller passes in. The scalar form narrows one element taken from the bottom of the source and zero-fills everything above it. A sticky flag records that some lane was clamped. It stays set until a dedicated synchronous clear input drops it.

All results are registered. A one-cycle `in_valid` pulse gives a one-cycle `out_valid` pulse on the next clock. Words that do not decode to a legal form are reported as illegal and change nothing.

Top module: `sat_narrow_unit`

## Requirements
- R1: An instruction word is a vector form when bit 31 is 0, bits 29:24 are 001110 and bits 21:10 are 100001010010. It is a scalar form when bits 31:24 are 01011110 and bits 21:10 are 100001010010. Bits 23:22 hold the size code. A word of neither form, or with size code 2'b11, gives `illegal`=1 with the result.
- R2: The narrow lane width is 8 << size (8, 16 or 32 bits) and the source lane width is twice that. Narrow lane e is produced from source lane e.
- R3: A source lane greater than the narrow signed maximum yields that maximum (0111…1). A lane below the narrow signed minimum yields that minimum (1000…0).
- R4: A source lane inside the narrow signed range is passed through unchanged in its low narrow bits, and its `lane_sat` bit is 0.
- R5: Vector form with Q (bit 30) = 0: `dst_new[63:0]` holds the result and `dst_new[127:64]` is zero.
- R6: Vector form with Q = 1: `dst_new[127:64]` holds the result and `dst_new[63:0]` equals the `dst_old[63:0]` supplied with the instruction.
- R7: Scalar form: only lane 0 is narrowed, from the low 2*esize source bits. Destination bits above esize are zero, and only `lane_sat` bit 0 can be set.
- R8: `lane_sat` bit e is 1 exactly when active lane e was clamped. Bits for lanes beyond the active count are 0.
- R9: `sticky_sat` becomes 1 after any legal operation that clamps a lane. An operation that clamps nothing never clears it.
- R10: `clr_sticky` clears `sticky_sat` on the next clock. If a clamping operation is accepted on that same clock, the flag ends set.
- R11: Results (`out_valid`, `wr_en`, `dst_new`, `lane_sat`, `rn_idx`=bits 9:5, `rd_idx`=bits 4:0, `illegal`) appear exactly one clock after `in_valid`, and `out_valid` is 0 otherwise.
- R12: An illegal word gives `wr_en`=0 and leaves `sticky_sat` unchanged.
- R13: Synchronous active-high `rst` clears `out_valid`, `wr_en` and `sticky_sat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_sticky | input | 1 | Synchronous clear of the sticky flag |
| in_valid | input | 1 | Instruction and operands valid this cycle |
| insn | input | 32 | Instruction word |
| src | input | VEC_W (128) | Source register value |
| dst_old | input | VEC_W (128) | Current destination register value |
| out_valid | output | 1 | Result valid (one cycle after in_valid) |
| wr_en | output | 1 | Write-back of dst_new requested |
| illegal | output | 1 | Word was not a legal encoding |
| dst_new | output | VEC_W (128) | Merged destination value |
| lane_sat | output | VEC_W/16 (8) | Per-lane clamp mask |
| rn_idx | output | 5 | Decoded source register index |
| rd_idx | output | 5 | Decoded destination register index |
| sticky_sat | output | 1 | Cumulative saturation flag |

## Verification
The bench aims at the exact clamp edges for every lane size: the narrow maximum and minimum themselves, which must pass untouched, and the values just outside them. A design that compares against the wrong bound either clamps a legal value or lets an overflowing one wrap. Both forms of half placement are checked with a non-zero old destination. A merge that mixes up the halves, or fails to zero the top, gives the wrong upper or lower bits. The scalar form gets source lanes above lane 0 that would saturate, so a unit that narrows more than one lane shows stray result bits or mask bits. The sticky flag is driven through clamp, quiet, illegal and clear sequences, including a clear on the same clock as a clamp, to catch a flag that drops too early or a clear with the wrong priority.

// File: rtl/snu_pkg.sv
package snu_pkg;
  localparam int INSN_W = 32;
  localparam int IDX_W  = 5;
  localparam int NMODES = 3;

  localparam logic [11:0] TAIL_CODE  = 12'b1000_0101_0010;
  localparam logic [5:0]  VEC_MAJOR  = 6'b001110;
  localparam logic [7:0]  SCA_MAJOR  = 8'b0101_1110;
  localparam logic [1:0]  SIZE_RSVD  = 2'b11;

  typedef enum logic [1:0] {
    FORM_NONE = 2'd0,
    FORM_VEC  = 2'd1,
    FORM_SCA  = 2'd2
  } form_e;

  typedef struct packed {
    form_e            form;
    logic [1:0]       size;
    logic             upper;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rd;
    logic             legal;
  } dec_t;
endpackage

// File: rtl/snu_decode.sv
module snu_decode
  import snu_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);
  logic tail_ok;
  logic is_vec;
  logic is_sca;

  always_comb begin
    tail_ok = (insn[21:10] == TAIL_CODE);
    is_vec  = !insn[31] && (insn[29:24] == VEC_MAJOR) && tail_ok;
    is_sca  = (insn[31:24] == SCA_MAJOR) && tail_ok;

    dec.size  = insn[23:22];
    dec.upper = is_vec && insn[30];
    dec.rn    = insn[9:5];
    dec.rd    = insn[4:0];
    if (is_vec)      dec.form = FORM_VEC;
    else if (is_sca) dec.form = FORM_SCA;
    else             dec.form = FORM_NONE;
    dec.legal = (is_vec || is_sca) && (insn[23:22] != SIZE_RSVD);
  end
endmodule

// File: rtl/snu_clamp.sv
module snu_clamp #(
  parameter int NW = 8
) (
  input  logic [2*NW-1:0] wide,
  output logic [NW-1:0]   narrow,
  output logic            clamped
);
  localparam int IW = 2 * NW;

  logic [IW-NW:0] head;
  logic           neg;

  always_comb begin
    head    = wide[IW-1:NW-1];
    neg     = wide[IW-1];
    clamped = !((&head) || !(|head));
    if (clamped) narrow = {neg, {(NW-1){!neg}}};
    else         narrow = wide[NW-1:0];
  end
endmodule

// File: rtl/snu_lane_bank.sv
module snu_lane_bank #(
  parameter int VEC_W = 128,
  parameter int NW    = 8
) (
  input  logic [VEC_W-1:0]            src,
  output logic [VEC_W/2-1:0]          res,
  output logic [(VEC_W/2)/NW-1:0]     sat
);
  localparam int HALF  = VEC_W / 2;
  localparam int LANES = HALF / NW;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    snu_clamp #(.NW(NW)) u_clamp (
      .wide    (src[e*2*NW +: 2*NW]),
      .narrow  (res[e*NW +: NW]),
      .clamped (sat[e])
    );
  end
endmodule

// File: rtl/snu_merge.sv
module snu_merge
  import snu_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  dec_t                                   dec,
  input  logic [NMODES-1:0][VEC_W/2-1:0]         res_all,
  input  logic [NMODES-1:0][VEC_W/16-1:0]        sat_all,
  input  logic [VEC_W-1:0]                       dst_old,
  output logic [VEC_W-1:0]                       dst_new,
  output logic [VEC_W/16-1:0]                    lane_sat
);
  localparam int HALF = VEC_W / 2;
  localparam int MAXL = VEC_W / 16;

  logic [HALF-1:0] pick_res;
  logic [MAXL-1:0] pick_sat;
  logic [HALF-1:0] lane0_mask;
  logic [1:0]      sel;

  always_comb begin
    sel = (dec.size == SIZE_RSVD) ? 2'd0 : dec.size;
    pick_res = res_all[sel];
    pick_sat = sat_all[sel];
    lane0_mask = '0;
    case (sel)
      2'd0:    lane0_mask[7:0]  = '1;
      2'd1:    lane0_mask[15:0] = '1;
      default: lane0_mask[31:0] = '1;
    endcase

    dst_new  = '0;
    lane_sat = '0;
    case (dec.form)
      FORM_VEC: begin
        lane_sat = pick_sat;
        if (dec.upper) dst_new = {pick_res, dst_old[HALF-1:0]};
        else           dst_new = {{HALF{1'b0}}, pick_res};
      end
      FORM_SCA: begin
        lane_sat[0]      = pick_sat[0];
        dst_new[HALF-1:0] = pick_res & lane0_mask;
      end
      default: begin
        dst_new  = '0;
        lane_sat = '0;
      end
    endcase
  end
endmodule

// File: rtl/sat_narrow_unit.sv
module sat_narrow_unit
  import snu_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr_sticky,
  input  logic                 in_valid,
  input  logic [31:0]          insn,
  input  logic [VEC_W-1:0]     src,
  input  logic [VEC_W-1:0]     dst_old,
  output logic                 out_valid,
  output logic                 wr_en,
  output logic                 illegal,
  output logic [VEC_W-1:0]     dst_new,
  output logic [VEC_W/16-1:0]  lane_sat,
  output logic [4:0]           rn_idx,
  output logic [4:0]           rd_idx,
  output logic                 sticky_sat
);
  localparam int HALF = VEC_W / 2;
  localparam int MAXL = VEC_W / 16;

  dec_t                          dec;
  logic [NMODES-1:0][HALF-1:0]   res_all;
  logic [NMODES-1:0][MAXL-1:0]   sat_all;
  logic [VEC_W-1:0]              merged;
  logic [MAXL-1:0]               merged_sat;
  logic                          any_sat;

  snu_decode u_decode (
    .insn (insn),
    .dec  (dec)
  );

  for (genvar m = 0; m < NMODES; m++) begin : g_mode
    localparam int NW    = 8 << m;
    localparam int LANES = HALF / NW;
    logic [LANES-1:0] bank_sat;

    snu_lane_bank #(.VEC_W(VEC_W), .NW(NW)) u_bank (
      .src (src),
      .res (res_all[m]),
      .sat (bank_sat)
    );
    assign sat_all[m] = MAXL'(bank_sat);
  end

  snu_merge #(.VEC_W(VEC_W)) u_merge (
    .dec      (dec),
    .res_all  (res_all),
    .sat_all  (sat_all),
    .dst_old  (dst_old),
    .dst_new  (merged),
    .lane_sat (merged_sat)
  );

  assign any_sat = dec.legal && (|merged_sat);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      wr_en      <= 1'b0;
      illegal    <= 1'b0;
      dst_new    <= '0;
      lane_sat   <= '0;
      rn_idx     <= '0;
      rd_idx     <= '0;
      sticky_sat <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      wr_en      <= in_valid && dec.legal;
      sticky_sat <= (sticky_sat && !clr_sticky) || (in_valid && any_sat);
      if (in_valid) begin
        illegal  <= !dec.legal;
        dst_new  <= dec.legal ? merged : '0;
        lane_sat <= dec.legal ? merged_sat : '0;
        rn_idx   <= dec.rn;
        rd_idx   <= dec.rd;
      end
    end
  end
endmodule

// File: rtl/snu_checker.sv
module snu_checker #(
  parameter int VEC_W = 128
) (
  input logic                clk,
  input logic                rst,
  input logic                clr_sticky,
  input logic                in_valid,
  input logic [31:0]         insn,
  input logic [VEC_W-1:0]    dst_old,
  input logic                out_valid,
  input logic                wr_en,
  input logic                illegal,
  input logic [VEC_W-1:0]    dst_new,
  input logic [VEC_W/16-1:0] lane_sat,
  input logic                sticky_sat
);
  localparam int HALF = VEC_W / 2;

  p_latency_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_no_write_r12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> !wr_en);

  p_sticky_keep_r12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal && !$past(clr_sticky)) |-> (sticky_sat == $past(sticky_sat)));

  p_sticky_set_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && wr_en && (|lane_sat)) |-> sticky_sat);

  p_sticky_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(sticky_sat) |-> ($past(clr_sticky) || $past(rst)));

  p_low_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && wr_en && !$past(insn[28]) && !$past(insn[30]))
      |-> (dst_new[VEC_W-1:HALF] == '0));

  p_low_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && wr_en && !$past(insn[28]) && $past(insn[30]))
      |-> (dst_new[HALF-1:0] == $past(dst_old[HALF-1:0])));

  p_scalar_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && wr_en && $past(insn[28]))
      |-> ((lane_sat >> 1) == '0 && dst_new[VEC_W-1:32] == '0));

  p_rsvd_size_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && insn[23:22] == 2'b11) |=> illegal);
endmodule

bind sat_narrow_unit snu_checker #(.VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_sticky (clr_sticky),
  .in_valid   (in_valid),
  .insn       (insn),
  .dst_old    (dst_old),
  .out_valid  (out_valid),
  .wr_en      (wr_en),
  .illegal    (illegal),
  .dst_new    (dst_new),
  .lane_sat   (lane_sat),
  .sticky_sat (sticky_sat)
);

// File: tb/tb_sat_narrow_unit.sv
module tb_sat_narrow_unit;
  localparam int VEC_W = 128;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             clr_sticky = 1'b0;
  logic             in_valid = 1'b0;
  logic [31:0]      insn = '0;
  logic [127:0]     src = '0;
  logic [127:0]     dst_old = '0;
  logic             out_valid, wr_en, illegal, sticky_sat;
  logic [127:0]     dst_new;
  logic [7:0]       lane_sat;
  logic [4:0]       rn_idx, rd_idx;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit model_sticky = 0;

  typedef struct {
    bit           ill;
    bit           wr;
    logic [127:0] dst;
    logic [7:0]   mask;
    logic [4:0]   rn;
    logic [4:0]   rd;
    bit           sticky;
    string        tag;
  } exp_t;

  exp_t sb[$];

  sat_narrow_unit #(.VEC_W(VEC_W)) dut (
    .clk(clk), .rst(rst), .clr_sticky(clr_sticky), .in_valid(in_valid),
    .insn(insn), .src(src), .dst_old(dst_old), .out_valid(out_valid),
    .wr_en(wr_en), .illegal(illegal), .dst_new(dst_new), .lane_sat(lane_sat),
    .rn_idx(rn_idx), .rd_idx(rd_idx), .sticky_sat(sticky_sat)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_vec(bit q, logic [1:0] sz, logic [4:0] rn, logic [4:0] rd);
    return {1'b0, q, 6'b001110, sz, 12'b100001010010, rn, rd};
  endfunction

  function automatic logic [31:0] enc_sca(logic [1:0] sz, logic [4:0] rn, logic [4:0] rd);
    return {8'b01011110, sz, 12'b100001010010, rn, rd};
  endfunction

  // Reference model built from the requirements
  function automatic exp_t model(logic [31:0] w, logic [127:0] s, logic [127:0] old);
    exp_t x;
    bit isv, iss;
    int nw, lanes;
    logic [63:0] res;
    isv = !w[31] && w[29:24] == 6'b001110 && w[21:10] == 12'b100001010010;
    iss = w[31:24] == 8'b01011110 && w[21:10] == 12'b100001010010;
    x.rn = w[9:5];
    x.rd = w[4:0];
    x.ill = !((isv || iss) && w[23:22] != 2'b11);
    x.wr = !x.ill;
    x.dst = '0;
    x.mask = '0;
    x.tag = "";
    if (x.ill) return x;
    nw = 8 << w[23:22];
    lanes = iss ? 1 : 64 / nw;
    res = '0;
    for (int e = 0; e < lanes; e++) begin
      logic [63:0] raw;
      longint v, hi, lo, c;
      raw = 64'(s >> (e * 2 * nw));
      v = $signed(raw << (64 - 2 * nw)) >>> (64 - 2 * nw);
      hi = (longint'(1) <<< (nw - 1)) - 1;
      lo = -(longint'(1) <<< (nw - 1));
      c = v;
      if (v > hi) begin c = hi; x.mask[e] = 1'b1; end
      if (v < lo) begin c = lo; x.mask[e] = 1'b1; end
      res = res | ((64'(c) & ((64'(1) << nw) - 1)) << (e * nw));
    end
    if (iss)        x.dst = {64'b0, res};
    else if (w[30]) x.dst = {res, old[63:0]};
    else            x.dst = {64'b0, res};
    return x;
  endfunction

  task automatic issue(logic [31:0] w, logic [127:0] s, logic [127:0] old, bit clr, string tag);
    exp_t x;
    x = model(w, s, old);
    if (clr) model_sticky = 0;
    if (!x.ill && x.mask != 0) model_sticky = 1;
    x.sticky = model_sticky;
    x.tag = tag;
    sb.push_back(x);
    @(negedge clk);
    insn = w; src = s; dst_old = old; in_valid = 1'b1; clr_sticky = clr;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0; clr_sticky = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_only();
    @(negedge clk);
    in_valid = 1'b0; clr_sticky = 1'b1;
    @(negedge clk);
    clr_sticky = 1'b0;
    model_sticky = 0;
    check(sticky_sat == 1'b0, "R10 clear", 128'(sticky_sat), 128'(0));
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R11 unexpected out_valid", 128'(1), 128'(0));
        end else begin
          exp_t x;
          x = sb.pop_front();
          check(illegal == x.ill, {"R1 illegal ", x.tag}, 128'(illegal), 128'(x.ill));
          check(wr_en == x.wr, {"R12 wr_en ", x.tag}, 128'(wr_en), 128'(x.wr));
          check(sticky_sat == x.sticky, {"R9 sticky ", x.tag}, 128'(sticky_sat), 128'(x.sticky));
          check(rn_idx == x.rn && rd_idx == x.rd, {"R11 indices ", x.tag},
                128'({rn_idx, rd_idx}), 128'({x.rn, x.rd}));
          if (!x.ill) begin
            check(dst_new == x.dst, {"R3 dst ", x.tag}, dst_new, x.dst);
            check(lane_sat == x.mask, {"R8 mask ", x.tag}, 128'(lane_sat), 128'(x.mask));
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] ones;
    ones = {128{1'b1}};
    repeat (4) @(negedge clk);
    // R13 reset state
    check(out_valid == 0 && wr_en == 0 && sticky_sat == 0, "R13 reset",
          128'({out_valid, wr_en, sticky_sat}), 128'(0));
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 0, "R11 idle no valid", 128'(out_valid), 128'(0));

    // R4 in-range boundaries, every size, no saturation
    issue(enc_vec(0, 2'd0, 5'd1, 5'd2),
          {16'h007F, 16'hFF80, 16'h0000, 16'hFFFF, 16'h0001, 16'h0042, 16'hFFC0, 16'h0010},
          ones, 0, "R4 b in-range");
    issue(enc_vec(1, 2'd1, 5'd3, 5'd4),
          {32'h00007FFF, 32'hFFFF8000, 32'h00000123, 32'hFFFFFFFE}, ones, 0, "R4 h in-range R6");
    issue(enc_vec(0, 2'd2, 5'd5, 5'd6),
          {64'h000000007FFFFFFF, 64'hFFFFFFFF80000000}, ones, 0, "R4 s in-range R5");
    idle(1);
    check(sticky_sat == 0, "R9 no sat keeps clear", 128'(sticky_sat), 128'(0));

    // R3 clamp edges per size, R2 lane mapping, R5 upper cleared
    issue(enc_vec(0, 2'd0, 5'd7, 5'd8),
          {16'h0080, 16'hFF7F, 16'h7FFF, 16'h8000, 16'h0005, 16'h1234, 16'hFF80, 16'h007F},
          ones, 0, "R3 b clamp R5");
    issue(enc_vec(1, 2'd1, 5'd9, 5'd10),
          {32'h00008000, 32'hFFFF7FFF, 32'h7FFFFFFF, 32'h00000001},
          128'h0123456789ABCDEF_FEDCBA9876543210, 0, "R3 h clamp R6");
    issue(enc_vec(1, 2'd2, 5'd11, 5'd12),
          {64'h0000000080000000, 64'hFFFFFFFF7FFFFFFF},
          128'hAAAAAAAAAAAAAAAA_5555555555555555, 0, "R3 s clamp R6");
    // R7 scalar: upper lanes would saturate but must be ignored
    issue(enc_sca(2'd0, 5'd13, 5'd14), {120'hFFFF_7FFF_7FFF_7FFF_7FFF_7FFF_7FFF_7F, 8'h00} | 128'h0000_0000_0000_0000_0000_0000_0000_0033,
          ones, 0, "R7 scalar b");
    issue(enc_sca(2'd1, 5'd15, 5'd16), {96'h7FFFFFFF_7FFFFFFF_7FFFFFFF, 32'hFFFF0000}, ones, 0, "R7 scalar h");
    issue(enc_sca(2'd2, 5'd17, 5'd18), {64'h7FFFFFFFFFFFFFFF, 64'h00000000FFFFFFFF}, ones, 0, "R7 scalar s");
    idle(1);
    check(sticky_sat == 1, "R9 sticky set", 128'(sticky_sat), 128'(1));

    // R9 quiet op keeps flag; R12 illegal keeps flag
    issue(enc_vec(0, 2'd0, 5'd1, 5'd1), 128'h0, ones, 0, "R9 quiet keeps");
    issue(enc_vec(0, 2'd3, 5'd2, 5'd3), {8{16'h7FFF}}, ones, 0, "R1 rsvd size R12");
    issue(enc_sca(2'd3, 5'd4, 5'd5), {8{16'h7FFF}}, ones, 0, "R1 rsvd scalar");
    issue(32'hDEADBEEF, {8{16'h8000}}, ones, 0, "R1 foreign word");
    issue(enc_vec(0, 2'd0, 5'd0, 5'd0) ^ 32'h0000_0400, {8{16'h8000}}, ones, 0, "R1 tail mismatch");
    idle(1);

    // R10 clear, then illegal saturating word must not set flag (R12)
    clear_only();
    issue(enc_vec(1, 2'd3, 5'd6, 5'd7), {8{16'h8000}}, ones, 0, "R12 illegal no set");
    issue(enc_vec(0, 2'd1, 5'd8, 5'd9), 128'h0, ones, 0, "R9 quiet zero");
    idle(1);
    // R10 clear with simultaneous saturating op: set wins
    issue(enc_vec(0, 2'd0, 5'd1, 5'd2), {8{16'h7FFF}}, ones, 0, "R9 set again");
    issue(enc_vec(0, 2'd0, 5'd3, 5'd4), {8{16'h7FFF}}, ones, 1, "R10 clr+sat");
    issue(enc_vec(0, 2'd0, 5'd3, 5'd4), 128'h0, ones, 1, "R10 clr+quiet");
    idle(1);

    // Mixed patterns across forms and sizes
    for (int i = 0; i < 48; i++) begin
      logic [127:0] s, o;
      logic [1:0] sz;
      logic [31:0] w;
      s = {$urandom, $urandom, $urandom, $urandom};
      o = {$urandom, $urandom, $urandom, $urandom};
      if (i % 3 == 0) s = s & {8{16'h00FF}} ^ {8{16'hFF80}} & {8{16'h0000 | 16'(i)}};
      sz = 2'(i % 4);
      if (i % 5 == 0) w = enc_sca(sz, 5'(i), 5'(31 - i));
      else            w = enc_vec(i[0], sz, 5'(i), 5'(i + 3));
      issue(w, s, o, (i % 11 == 0), "R2 mixed");
    end
    idle(3);
    check(sb.size() == 0, "R11 all results seen", 128'(sb.size()), 128'(0));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule